// File: doc/BRIEF.md
# Prescaled 16-bit Down Timer

This block is a register-mapped countdown timer. A divider that never stops turns the input clock into a decrement strobe, one every `PRESCALE` clocks. On each strobe, and only while the block is switched on, a 16-bit counter steps down by one. When the counter steps down from zero, an interrupt request flag is set. The counter then refills, either from the programmed start value (repeating mode) or with all ones (wrap mode).

Software controls the timer through a 32-bit word bus with four registers. The start-value register restarts the counter as soon as it is written. The counter value can be read but not written. The control register holds the on bit, the repeat bit and one spare bit. The acknowledge register drops the interrupt request when it is written. The request is a level output meant for an interrupt controller.

Top module: `tick_down_timer`

## Requirements
- R1: After reset the start value, counter, control register and interrupt request are all zero.
- R2: A write to word address 0x0 stores only the low 16 bits of the write data as the start value. Reading 0x0 returns it with the upper 16 bits zero. Address bits [1:0] are ignored when decoding.
- R3: A write to 0x0 copies the new start value into the counter at the same clock edge. This write takes precedence over a decrement strobe in that cycle, and that edge raises no underflow.
- R4: A write to 0x8 keeps only bits 7, 6 and 2 of the data (mask 0xC4), and every other bit reads as zero. Bit 2 is storage only: it changes no behaviour.
- R5: The counter (read at 0x4) decreases by exactly one once every `PRESCALE` clocks when control bit 7 is set. It holds its value when bit 7 is clear. The divider runs whether or not bit 7 is set.
- R6: A decrement that starts from zero is an underflow. It sets the interrupt request, and the request stays high until it is acknowledged.
- R7: On underflow with control bit 6 set, the counter reloads from the start value.
- R8: On underflow with control bit 6 clear, the counter becomes 0xFFFF.
- R9: A write of any data to 0xC clears the interrupt request at that edge. Reading 0xC returns zero.
- R10: When a write to 0xC and an underflow happen at the same edge, the interrupt request remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; bits [3:2] select the register |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest cases to reach depend on the edge where the hidden divider fires. These are an acknowledge that lands exactly on an underflow, and a start-value write that lands exactly on a decrement strobe. The bench runs its own model of the divider phase. It launches those writes only when the model shows that the next edge carries the strobe. For the acknowledge case, a start value of zero in repeating mode makes every strobe an underflow. A small divisor keeps the wrap-mode run and the repeating-mode run short, and the model is compared with the ports on every clock.

// File: rtl/tdt_pkg.sv
package tdt_pkg;
  localparam int CTRL_W    = 8;
  localparam int EN_BIT    = 7;
  localparam int PER_BIT   = 6;
  localparam int SPARE_BIT = 2;
  localparam logic [CTRL_W-1:0] CTRL_KEEP = 8'hC4;

  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_VALUE = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_ACK   = 2'd3
  } reg_sel_e;

  function automatic logic [CTRL_W-1:0] ctrl_filter(input logic [CTRL_W-1:0] raw);
    return raw & CTRL_KEEP;
  endfunction
endpackage

// File: rtl/tdt_prescaler.sv
module tdt_prescaler #(
  parameter int DIV = 5000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_bypass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] phase_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                   phase_q <= phase_q + 1'b1;
      end

      assign tick = (phase_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/tdt_counter.sv
module tdt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             enable,
  input  logic             periodic,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_data,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt,
  output logic             uflow
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  function automatic logic [CNT_W-1:0] step_value(
    input logic [CNT_W-1:0] cur,
    input logic             rep,
    input logic [CNT_W-1:0] start
  );
    if (cur == '0) return rep ? start : ALL_ONES;
    return cur - 1'b1;
  endfunction

  logic             step;
  logic [CNT_W-1:0] cnt_q;

  assign step  = tick & enable & ~load_wr;
  assign uflow = step & (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (load_wr) cnt_q <= load_data;
    else if (step)    cnt_q <= step_value(cnt_q, periodic, reload_val);
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tdt_regfile.sv
module tdt_regfile
  import tdt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              uflow,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [CNT_W-1:0]  load_q,
  output logic [CNT_W-1:0]  load_data,
  output logic              load_wr,
  output logic              eoi_wr,
  output logic              ctrl_en,
  output logic              ctrl_per,
  output logic              irq
);
  reg_sel_e          sel;
  logic [CTRL_W-1:0] ctrl_q;
  logic              irq_q;
  logic              ctrl_wr;
  logic              unused_bits;

  assign sel         = reg_sel_e'(bus_addr[3:2]);
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:CNT_W]};

  assign load_wr   = bus_we && (sel == SEL_START);
  assign ctrl_wr   = bus_we && (sel == SEL_CTRL);
  assign eoi_wr    = bus_we && (sel == SEL_ACK);
  assign load_data = bus_wdata[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (load_wr) load_q <= load_data;
      if (ctrl_wr) ctrl_q <= ctrl_filter(bus_wdata[CTRL_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (uflow)  irq_q <= 1'b1;
    else if (eoi_wr) irq_q <= 1'b0;
  end

  always_comb begin
    unique case (sel)
      SEL_START: bus_rdata = DATA_W'(load_q);
      SEL_VALUE: bus_rdata = DATA_W'(cnt);
      SEL_CTRL:  bus_rdata = DATA_W'(ctrl_q);
      default:   bus_rdata = '0;
    endcase
  end

  assign ctrl_en  = ctrl_q[EN_BIT];
  assign ctrl_per = ctrl_q[PER_BIT];
  assign irq      = irq_q;
endmodule

// File: rtl/tick_down_timer.sv
module tick_down_timer #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 16,
  parameter int PRESCALE = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic             pre_tick;
  logic             uflow;
  logic             load_wr;
  logic             eoi_wr;
  logic             ctrl_en;
  logic             ctrl_per;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] load_data;

  tdt_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (pre_tick)
  );

  tdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (pre_tick),
    .enable    (ctrl_en),
    .periodic  (ctrl_per),
    .load_wr   (load_wr),
    .load_data (load_data),
    .reload_val(load_q),
    .cnt       (cnt_q),
    .uflow     (uflow)
  );

  tdt_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .cnt      (cnt_q),
    .uflow    (uflow),
    .bus_rdata(bus_rdata),
    .load_q   (load_q),
    .load_data(load_data),
    .load_wr  (load_wr),
    .eoi_wr   (eoi_wr),
    .ctrl_en  (ctrl_en),
    .ctrl_per (ctrl_per),
    .irq      (irq)
  );
endmodule

// File: rtl/tdt_checker.sv
module tdt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             uflow,
  input logic             load_wr,
  input logic             eoi_wr,
  input logic             enable,
  input logic             periodic,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] load_q,
  input logic [CNT_W-1:0] load_data,
  input logic             irq
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  a_r3_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> (cnt == $past(load_data)));

  a_r5_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && enable && !load_wr && cnt != '0) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

  a_r5_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_wr && !(tick && enable)) |=> $stable(cnt));

  a_r6_underflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
    uflow |=> irq);

  a_r6_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(uflow));

  a_r7_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && periodic) |=> (cnt == $past(load_q)));

  a_r8_free_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && !periodic) |=> (cnt == ALL_ONES));

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && !uflow) |=> !irq);

  a_r10_underflow_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && uflow) |=> irq);
endmodule

bind tick_down_timer tdt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (pre_tick),
  .uflow    (uflow),
  .load_wr  (load_wr),
  .eoi_wr   (eoi_wr),
  .enable   (ctrl_en),
  .periodic (ctrl_per),
  .cnt      (cnt_q),
  .load_q   (load_q),
  .load_data(load_data),
  .irq      (irq)
);

// File: tb/test_tick_down_timer.sv
module test_tick_down_timer;
  localparam int CLK_PERIOD = 10;
  localparam int PRE        = 4;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_pre = 0;
  int m_cnt = 0;
  int m_load = 0;
  int m_ctrl = 0;
  bit m_irq = 0;

  tick_down_timer #(.PRESCALE(PRE)) i_tick_down_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic int exp_rdata();
    case (addr[3:2])
      2'd0: return m_load;
      2'd1: return m_cnt;
      2'd2: return m_ctrl;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_load = 0; m_ctrl = 0; m_irq = 0;
    end else begin
      bit t;
      bit uf;
      t  = (m_pre == PRE - 1);
      m_pre = t ? 0 : m_pre + 1;
      uf = 0;
      if (we && addr[3:2] == 2'd0) begin
        m_load = int'(wdata % 65536);
        m_cnt  = m_load;
      end else if (t && m_ctrl >= 128) begin
        if (m_cnt == 0) begin
          uf = 1;
          m_cnt = ((m_ctrl / 64) % 2 == 1) ? m_load : 65535;
        end else m_cnt = m_cnt - 1;
      end
      if (we && addr[3:2] == 2'd2) m_ctrl = int'(wdata % 256) & 196;
      if (uf) m_irq = 1;
      else if (we && addr[3:2] == 2'd3) m_irq = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_req, "model rdata", rdata, exp_rdata());
      check(cur_req, "model irq", irq, m_irq);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic align_to_tick();
    for (int i = 0; i < 4 * PRE; i++) begin
      @(posedge clk); #1;
      if (m_pre == PRE - 1) break;
    end
  endtask

  task automatic wait_irq(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (irq) break;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int r = 0; r < 4; r++) begin
      addr = 4'(r * 4);
      @(negedge clk);
      check("R1", "reset register", rdata, 0);
    end
    check("R1", "reset irq", irq, 0);

    // R2 upper bits dropped, byte bits ignored
    cur_req = "R2";
    wr(4'h0, 32'hABCD_1234);
    addr = 4'h3;
    @(negedge clk);
    check("R2", "start value masked", rdata, 32'h0000_1234);

    // R3 immediate copy into counter
    cur_req = "R3";
    addr = 4'h4;
    @(negedge clk);
    check("R3", "counter after start write", rdata, 32'h1234);

    // R4 control mask
    cur_req = "R4";
    wr(4'h8, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R4", "control mask", rdata, 32'hC4);
    wr(4'h8, 32'h0000_0000);

    // R5 disabled: counter holds
    cur_req = "R5";
    addr = 4'h4;
    @(negedge clk);
    begin
      logic [31:0] v0;
      v0 = rdata;
      repeat (5 * PRE) @(negedge clk);
      check("R5", "hold while off", rdata, v0);
    end

    // R5 enabled: one step per PRE clocks
    wr(4'h0, 32'd100);
    wr(4'h8, 32'h80);
    addr = 4'h4;
    repeat (PRE) @(negedge clk);
    begin
      logic [31:0] v1;
      v1 = rdata;
      repeat (PRE) @(negedge clk);
      check("R5", "one step per period", rdata, v1 - 1);
    end

    // R3 start write on a strobe edge wins
    cur_req = "R3";
    align_to_tick();
    we = 1'b1; addr = 4'h0; wdata = 32'h50;
    @(posedge clk); #1;
    we = 1'b0; addr = 4'h4;
    @(negedge clk);
    check("R3", "start write beats strobe", rdata, 32'h50);
    check("R3", "no underflow on start write", irq, 0);

    // R6 and R7 periodic underflow (spare bit 2 set, R4 no effect)
    cur_req = "R7";
    wr(4'h8, 32'h0);
    wr(4'h0, 32'd2);
    wr(4'h8, 32'hC4);
    addr = 4'h4;
    wait_irq(10 * PRE);
    check("R6", "irq after underflow", irq, 1);
    check("R7", "reloaded from start", rdata, 32'd2);
    repeat (3 * PRE) @(negedge clk);
    check("R6", "irq held as level", irq, 1);

    // R9 acknowledge clears, reads zero
    cur_req = "R9";
    wr(4'h8, 32'h0);
    wr(4'hC, 32'h0);
    @(negedge clk);
    check("R9", "irq cleared", irq, 0);
    check("R9", "ack reads zero", rdata, 0);

    // R8 wrap mode
    cur_req = "R8";
    wr(4'h0, 32'd1);
    wr(4'h8, 32'h80);
    addr = 4'h4;
    wait_irq(10 * PRE);
    check("R8", "irq in wrap mode", irq, 1);
    check("R8", "wrapped to all ones", rdata, 32'hFFFF);
    repeat (PRE) @(negedge clk);
    check("R8", "keeps counting after wrap", rdata, 32'hFFFE);
    wr(4'hC, 32'h1);

    // R10 acknowledge on an underflow edge
    cur_req = "R10";
    wr(4'h0, 32'd0);
    wr(4'h8, 32'hC0);
    wait_irq(4 * PRE);
    align_to_tick();
    we = 1'b1; addr = 4'hC; wdata = 32'hDEAD;
    @(posedge clk); #1;
    we = 1'b0;
    @(negedge clk);
    check("R10", "underflow beats ack", irq, 1);
    cur_req = "R9";
    wr(4'hC, 32'h0);
    @(negedge clk);
    check("R9", "ack off strobe clears", irq, 0);

    wr(4'h8, 32'h0);
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule